// File: doc/BRIEF.md
# Single-Cycle Two-Register 16-bit Processor Core

This block is a small 16-bit processor core that completes every instruction in one clock. It has two working registers, an address/operand register and a data register, plus a program counter. The core drives a 15-bit fetch address to a separate instruction store and decodes the word that comes back in the same cycle. No instruction register holds that word. The address register also drives the data-store address. The data-store word at that address can serve as the second ALU operand, and it is written from the ALU result when the instruction asks for it.

There are two instruction kinds. A constant load puts a 15-bit literal into the address register. A compute instruction runs the ALU on the data register and a selectable second operand, stores the result into any mix of the address register, the data register and the data store, and may branch to the address held in the address register, depending on the sign and zero state of the result. The instruction and data stores are outside the block. The bench models them by driving `instrWord` and `memRdata` directly.

Top module: `acc16_core`

## Requirements
- R1: While `rst` is 1, `instrAddr` is 0 after the next clock edge and `memWe` is 0. The address and data registers clear to 0. Execution then starts at address 0 once `rst` returns to 0.
- R2: An instruction with bit 15 = 0 loads bits 14:0, zero-extended, into the address register. The new value appears on `memAddr` after the clock edge.
- R3: For a compute instruction, `memWdata` shows the ALU result in the same cycle. The x operand is the data register. Bits 11:6 are six controls applied in order from bit 11 to bit 6: clear x, invert x, clear y, invert y, select add (1) or bitwise AND (0), and invert the result.
- R4: Bit 12 selects the y operand: 0 selects the address register and 1 selects `memRdata`.
- R5: The destination bits are bit 5 for the address register, bit 4 for the data register and bit 3 for the data store. Each set bit stores the ALU result at the clock edge. A clear bit leaves that destination unchanged.
- R6: `memWe` is 1 only for a compute instruction with bit 3 set. During that cycle `memAddr` holds the address-register value from before the instruction.
- R7: Bits 2:0 of a compute instruction enable a branch when the result is negative (bit 2), zero (bit 1) or positive (bit 0). If any enabled condition holds, the program counter loads the address register.
- R8: In every other case, including all constant loads, the fetch address increments by one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instrWord | input | 16 | Instruction word fetched from `instrAddr` |
| instrAddr | output | 15 | Instruction fetch address (program counter) |
| memRdata | input | 16 | Data-store word at `memAddr` |
| memAddr | output | 15 | Data-store address (address register) |
| memWdata | output | 16 | ALU result, the write data for the data store |
| memWe | output | 1 | Data-store write enable |

## Verification
Nearly all core state reaches a port within one clock. The address register is visible on `memAddr` as soon as the edge passes. The data register shows up on `memWdata` in the same cycle as any instruction that routes x through the ALU. The program counter is `instrAddr` itself. A wrong branch decision therefore shows as a wrong fetch address on the very next cycle. A wrong destination decode shows as a stale or changed `memAddr`, or a wrong data value, on the instruction that follows. A spurious store shows at once on `memWe`.

// File: rtl/acc16_pkg.sv
package acc16_pkg;

  typedef struct packed {
    logic zeroX;
    logic invX;
    logic zeroY;
    logic invY;
    logic addSel;
    logic invOut;
  } aluCtl_t;

  typedef struct packed {
    logic       isCompute;
    logic       yFromMem;
    aluCtl_t    alu;
    logic       loadA;
    logic       loadD;
    logic       writeMem;
    logic [2:0] jumpMask;   // {neg, zero, pos}
  } ctlStrobe_t;

endpackage

// File: rtl/acc16_alu.sv
module acc16_alu
  import acc16_pkg::*;
#(
  parameter int DataW = 16
) (
  input  logic [DataW-1:0] opX,
  input  logic [DataW-1:0] opY,
  input  aluCtl_t          ctl,
  output logic [DataW-1:0] result,
  output logic             isZero,
  output logic             isNeg
);
  logic [DataW-1:0] xA, xB, yA, yB, raw;

  always_comb begin
    xA     = ctl.zeroX ? '0 : opX;
    xB     = ctl.invX ? ~xA : xA;
    yA     = ctl.zeroY ? '0 : opY;
    yB     = ctl.invY ? ~yA : yA;
    raw    = ctl.addSel ? (xB + yB) : (xB & yB);
    result = ctl.invOut ? ~raw : raw;
    isZero = (result == '0);
    isNeg  = result[DataW-1];
  end
endmodule

// File: rtl/acc16_ctrl.sv
module acc16_ctrl
  import acc16_pkg::*;
#(
  parameter int DataW = 16
) (
  input  logic             rst,
  input  logic [DataW-1:0] instrWord,
  output ctlStrobe_t       strobes
);
  logic compute;
  logic unusedCtl;

  assign compute   = instrWord[DataW-1];
  assign unusedCtl = ^instrWord[DataW-2:13];

  always_comb begin
    strobes.isCompute  = compute;
    strobes.yFromMem   = compute & instrWord[12];
    strobes.alu.zeroX  = instrWord[11];
    strobes.alu.invX   = instrWord[10];
    strobes.alu.zeroY  = instrWord[9];
    strobes.alu.invY   = instrWord[8];
    strobes.alu.addSel = instrWord[7];
    strobes.alu.invOut = instrWord[6];
    strobes.loadA      = compute & instrWord[5];
    strobes.loadD      = compute & instrWord[4];
    strobes.writeMem   = compute & instrWord[3] & ~rst;
    strobes.jumpMask   = compute ? instrWord[2:0] : 3'b000;
  end
endmodule

// File: rtl/acc16_dpath.sv
module acc16_dpath
  import acc16_pkg::*;
#(
  parameter int DataW = 16,
  localparam int AddrW = DataW - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DataW-1:0] instrWord,
  input  logic [DataW-1:0] memRdata,
  input  ctlStrobe_t       strobes,
  output logic [AddrW-1:0] instrAddr,
  output logic [AddrW-1:0] memAddr,
  output logic [DataW-1:0] memWdata
);
  logic [DataW-1:0] regA, regD, pc;
  logic [DataW-1:0] yOp, aluRes;
  logic             resZero, resNeg, takeBranch;
  logic             unusedDp;

  assign yOp = strobes.yFromMem ? memRdata : regA;

  acc16_alu #(.DataW(DataW)) uAlu (
    .opX   (regD),
    .opY   (yOp),
    .ctl   (strobes.alu),
    .result(aluRes),
    .isZero(resZero),
    .isNeg (resNeg)
  );

  assign takeBranch = |(strobes.jumpMask & {resNeg, resZero, ~resNeg & ~resZero});

  always_ff @(posedge clk) begin
    if (rst) begin
      pc   <= '0;
      regA <= '0;
      regD <= '0;
    end else begin
      pc <= takeBranch ? regA : pc + 1'b1;
      if (!strobes.isCompute)
        regA <= {1'b0, instrWord[AddrW-1:0]};
      else if (strobes.loadA)
        regA <= aluRes;
      if (strobes.loadD)
        regD <= aluRes;
    end
  end

  assign instrAddr = pc[AddrW-1:0];
  assign memAddr   = regA[AddrW-1:0];
  assign memWdata  = aluRes;
  assign unusedDp  = pc[DataW-1];
endmodule

// File: rtl/acc16_core.sv
module acc16_core
  import acc16_pkg::*;
#(
  parameter int DataW = 16,
  localparam int AddrW = DataW - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DataW-1:0] instrWord,
  output logic [AddrW-1:0] instrAddr,
  input  logic [DataW-1:0] memRdata,
  output logic [AddrW-1:0] memAddr,
  output logic [DataW-1:0] memWdata,
  output logic             memWe
);
  ctlStrobe_t strobes;

  acc16_ctrl #(.DataW(DataW)) uCtrl (
    .rst      (rst),
    .instrWord(instrWord),
    .strobes  (strobes)
  );

  acc16_dpath #(.DataW(DataW)) uDpath (
    .clk      (clk),
    .rst      (rst),
    .instrWord(instrWord),
    .memRdata (memRdata),
    .strobes  (strobes),
    .instrAddr(instrAddr),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

  assign memWe = strobes.writeMem;
endmodule

// File: rtl/acc16_checker.sv
module acc16_checker #(
  parameter int DataW = 16,
  localparam int AddrW = DataW - 1
) (
  input logic             clk,
  input logic             rst,
  input logic [DataW-1:0] instrWord,
  input logic [AddrW-1:0] instrAddr,
  input logic [AddrW-1:0] memAddr,
  input logic             memWe
);
  // R1: the first edge after reset release sees fetch address 0
  a_r1_start_zero: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> instrAddr == '0);

  // R1: no store while reset is held
  always_comb begin
    if (rst) a_r1_no_store_in_reset: assert (!memWe);
  end

  // R6: a store needs a compute instruction with the data-store destination
  always_comb begin
    if (memWe) a_r6_store_decode: assert (instrWord[DataW-1] && instrWord[3]);
  end

  // R2: a constant load reaches the address port after the edge
  a_r2_const_load: assert property (@(posedge clk) disable iff (rst)
    !instrWord[DataW-1] |=> memAddr == $past(instrWord[AddrW-1:0]));

  // R8: a constant load advances the fetch address by one
  a_r8_const_step: assert property (@(posedge clk) disable iff (rst)
    !instrWord[DataW-1] |=> instrAddr == $past(instrAddr) + 1'b1);

  // R8: a compute with no jump bits advances by one
  a_r8_no_jump_step: assert property (@(posedge clk) disable iff (rst)
    (instrWord[DataW-1] && instrWord[2:0] == 3'b000) |=> instrAddr == $past(instrAddr) + 1'b1);

  // R7: all three jump bits set always branches to the address register
  a_r7_always_jump: assert property (@(posedge clk) disable iff (rst)
    (instrWord[DataW-1] && instrWord[2:0] == 3'b111) |=> instrAddr == $past(memAddr));
endmodule

bind acc16_core acc16_checker #(.DataW(DataW)) uChk (
  .clk      (clk),
  .rst      (rst),
  .instrWord(instrWord),
  .instrAddr(instrAddr),
  .memAddr  (memAddr),
  .memWe    (memWe)
);

// File: tb/acc16_core_test.sv
`timescale 1ns/1ps
module acc16_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instrWord = 16'h0000;
  logic [15:0] memRdata = 16'h0000;
  logic [14:0] instrAddr, memAddr;
  logic [15:0] memWdata;
  logic        memWe;
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  acc16_core uut (
    .clk(clk), .rst(rst), .instrWord(instrWord), .instrAddr(instrAddr),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe)
  );

  function automatic logic [15:0] aLoad(input logic [14:0] v);
    return {1'b0, v};
  endfunction

  function automatic logic [15:0] cmp(input logic a, input logic [5:0] c,
                                      input logic [2:0] d, input logic [2:0] j);
    return {3'b111, a, c, d, j};
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // drive on the falling edge, then let combinational outputs settle
  task automatic step(input logic [15:0] w);
    @(negedge clk);
    instrWord = w;
    #1;
  endtask

  task automatic testReset();
    rst = 1'b1;
    step(cmp(1'b0, 6'b111111, 3'b001, 3'b111));
    check("R1 memWe low in reset", {15'd0, memWe}, 16'd0);
    step(aLoad(15'h0123));
    check("R1 pc zero in reset", {1'b0, instrAddr}, 16'd0);
    check("R1 A cleared in reset", {1'b0, memAddr}, 16'd0);
  endtask

  task automatic testRelease();
    @(negedge clk);
    rst = 1'b0;
    instrWord = aLoad(15'h0003);
    #1;
    check("R1 first fetch at 0", {1'b0, instrAddr}, 16'd0);
    step(aLoad(15'h0011));
    check("R8 pc step 1", {1'b0, instrAddr}, 16'd1);
    check("R2 A load 3", {1'b0, memAddr}, 16'h0003);
    check("R6 no store on A load", {15'd0, memWe}, 16'd0);
    step(aLoad(15'h7FFF));
    check("R8 pc step 2", {1'b0, instrAddr}, 16'd2);
    check("R2 A load 0x11", {1'b0, memAddr}, 16'h0011);
    step(cmp(1'b0, 6'b110000, 3'b000, 3'b000));
    check("R2 A load max", {1'b0, memAddr}, 16'h7FFF);
    check("R3 pass A zero-extended", memWdata, 16'h7FFF);
  endtask

  task automatic testAlu();
    step(aLoad(15'd5));
    step(cmp(1'b0, 6'b110000, 3'b010, 3'b000));          // D = A = 5
    step(aLoad(15'd3));
    step(cmp(1'b0, 6'b001100, 3'b000, 3'b000)); check("R3 D", memWdata, 16'd5);
    step(cmp(1'b0, 6'b110000, 3'b000, 3'b000)); check("R3 A", memWdata, 16'd3);
    step(cmp(1'b0, 6'b000010, 3'b000, 3'b000)); check("R3 D+A", memWdata, 16'd8);
    step(cmp(1'b0, 6'b010011, 3'b000, 3'b000)); check("R3 D-A", memWdata, 16'd2);
    step(cmp(1'b0, 6'b000111, 3'b000, 3'b000)); check("R3 A-D", memWdata, 16'hFFFE);
    step(cmp(1'b0, 6'b000000, 3'b000, 3'b000)); check("R3 D&A", memWdata, 16'd1);
    step(cmp(1'b0, 6'b010101, 3'b000, 3'b000)); check("R3 D|A", memWdata, 16'd7);
    step(cmp(1'b0, 6'b001101, 3'b000, 3'b000)); check("R3 !D", memWdata, 16'hFFFA);
    step(cmp(1'b0, 6'b001111, 3'b000, 3'b000)); check("R3 -D", memWdata, 16'hFFFB);
    step(cmp(1'b0, 6'b111111, 3'b000, 3'b000)); check("R3 one", memWdata, 16'd1);
    step(cmp(1'b0, 6'b111010, 3'b000, 3'b000)); check("R3 minus one", memWdata, 16'hFFFF);
    step(cmp(1'b0, 6'b101010, 3'b000, 3'b000)); check("R3 zero", memWdata, 16'd0);
    step(cmp(1'b0, 6'b011111, 3'b000, 3'b000)); check("R3 D+1", memWdata, 16'd6);
    step(cmp(1'b0, 6'b110010, 3'b000, 3'b000)); check("R3 A-1", memWdata, 16'd2);
  endtask

  task automatic testMemOperand();
    memRdata = 16'h0100;                                  // A=3, D=5
    step(cmp(1'b1, 6'b110000, 3'b000, 3'b000)); check("R4 M", memWdata, 16'h0100);
    step(cmp(1'b1, 6'b000010, 3'b000, 3'b000)); check("R4 D+M", memWdata, 16'h0105);
    step(cmp(1'b0, 6'b000010, 3'b000, 3'b000)); check("R4 D+A with a=0", memWdata, 16'd8);
    step(cmp(1'b1, 6'b000111, 3'b000, 3'b000)); check("R4 M-D", memWdata, 16'h00FB);
  endtask

  task automatic testDest();
    step(aLoad(15'h0020));
    step(cmp(1'b0, 6'b011111, 3'b101, 3'b000));          // A,M = D+1
    check("R6 store enable", {15'd0, memWe}, 16'd1);
    check("R6 store address is old A", {1'b0, memAddr}, 16'h0020);
    check("R5 store data", memWdata, 16'd6);
    step(cmp(1'b0, 6'b001100, 3'b000, 3'b000));
    check("R5 A written", {1'b0, memAddr}, 16'd6);
    check("R5 D untouched", memWdata, 16'd5);
    check("R6 no store without bit 3", {15'd0, memWe}, 16'd0);
    step(aLoad(15'd9));
    step(cmp(1'b0, 6'b110000, 3'b010, 3'b000));          // D = 9
    step(cmp(1'b0, 6'b001100, 3'b000, 3'b000));
    check("R5 D written", memWdata, 16'd9);
    check("R5 A untouched by D dest", {1'b0, memAddr}, 16'd9);
  endtask

  task automatic jumpCase(input string tag, input logic [5:0] c,
                          input logic [2:0] mask, input bit taken);
    logic [14:0] pcNow;
    step(aLoad(15'h0040));
    step(cmp(1'b0, c, 3'b000, mask));
    pcNow = instrAddr;
    step(aLoad(15'd0));
    check(tag, {1'b0, instrAddr}, taken ? 16'h0040 : {1'b0, pcNow + 15'd1});
  endtask

  task automatic testJump();
    jumpCase("R7 eq on zero taken",      6'b101010, 3'b010, 1'b1);
    jumpCase("R7 lt|gt on zero not",     6'b101010, 3'b101, 1'b0);
    jumpCase("R7 gt on one taken",       6'b111111, 3'b001, 1'b1);
    jumpCase("R7 lt|eq on one not",      6'b111111, 3'b110, 1'b0);
    jumpCase("R7 lt on minus one taken", 6'b111010, 3'b100, 1'b1);
    jumpCase("R7 eq|gt on minus one not",6'b111010, 3'b011, 1'b0);
    jumpCase("R8 no mask no jump",       6'b101010, 3'b000, 1'b0);
    jumpCase("R7 all bits jump",         6'b111111, 3'b111, 1'b1);
  endtask

  task automatic testMidReset();
    step(aLoad(15'h0055));
    @(negedge clk);
    rst = 1'b1;
    instrWord = cmp(1'b0, 6'b111111, 3'b001, 3'b000);
    #1;
    check("R1 no store when reset asserted", {15'd0, memWe}, 16'd0);
    step(aLoad(15'd1));
    check("R1 pc back to 0", {1'b0, instrAddr}, 16'd0);
    @(negedge clk);
    rst = 1'b0;
    instrWord = aLoad(15'd2);
    #1;
    step(aLoad(15'd3));
    check("R8 restart step", {1'b0, instrAddr}, 16'd1);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    testReset();
    testRelease();
    testAlu();
    testMemOperand();
    testDest();
    testJump();
    testMidReset();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule